// File: doc/BRIEF.md
# Width-Selectable Status Flag Register

This block is the processor status register of a small CPU core. It keeps a data-width mode bit, the signed-overflow flag, the negative flag, five general flag bits and a three-bit interrupt priority field. While the mode bit is 0 the core works on 16-bit data, and while it is 1 the core works on 8-bit data. After each add or subtract, the block derives overflow and negative from the sign and carry bits of whichever lane the mode bit selects. A data-transfer result updates only the negative flag. Results produced in decimal mode leave both flags as they were.

Software changes the low byte through several explicit commands. There are dedicated commands that set or clear the mode bit, a dedicated command that clears overflow, and a pair of masked commands that set or clear any of bits 0-7. Returning from an interrupt writes the complete register from the stack in one cycle. That load is the only way to write the priority field. The ALU datapath and the stack memory are outside this block. The ALU supplies the result sign bits and the carries around bit 7 and bit 15 of each lane.

Top module: `status_flag_reg`

## Requirements
- R1: While reset is asserted, `sr_out` reads 0. After reset, the mode bit (bit 5) and the priority field (bits 10:8) are 0.
- R2: `cmd_set_m` makes bit 5 equal to 1 and `cmd_clr_m` makes it 0, both on the next clock. When both are given in the same cycle, bit 5 becomes 0.
- R3: With bit 5 at 0, an arithmetic result sets bit 6 (V) to `res_cin_msb[1]` XOR `res_cout_msb[1]`. Index 1 is the carry into and out of bit 15, so V is 1 exactly when the signed 16-bit result lies outside -32768..+32767.
- R4: With bit 5 at 1, an arithmetic result sets V to `res_cin_msb[0]` XOR `res_cout_msb[0]`. Index 0 is the carry into and out of bit 7, so V is 1 exactly when the signed 8-bit result lies outside -128..+127. The 16-bit carries are ignored.
- R5: For every non-decimal result, bit 7 (N) takes `res_sign[1]` (result bit 15) when bit 5 is 0 and `res_sign[0]` (result bit 7) when bit 5 is 1.
- R6: A data-transfer result (`res_arith`=0) updates N only and leaves V unchanged.
- R7: A result flagged with `dec_mode`=1 leaves V and N unchanged.
- R8: `cmd_mask_set` sets, and `cmd_mask_clr` clears, every bit among 0-7 whose `cmd_mask` bit is 1. A mask of 0 leaves the register unchanged.
- R9: `cmd_clr_v` clears V. Within one cycle, clears take priority over sets, and all commands take priority over flags derived from the result.
- R10: `pull_valid` loads all 11 bits from `pull_data` on the next clock and overrides every other input. Bits 10:8 change only through this load.
- R11: Flags from a result are evaluated with the mode bit held before the current cycle, even when a mode command arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_valid | input | 1 | A result is present this cycle |
| res_arith | input | 1 | 1: add/subtract result, 0: data-transfer result |
| dec_mode | input | 1 | Result was produced in decimal mode |
| res_sign | input | 2 | Result bit 7 ([0]) and bit 15 ([1]) |
| res_cin_msb | input | 2 | Carry into bit 7 ([0]) and bit 15 ([1]) |
| res_cout_msb | input | 2 | Carry out of bit 7 ([0]) and bit 15 ([1]) |
| cmd_set_m | input | 1 | Set the mode bit |
| cmd_clr_m | input | 1 | Clear the mode bit |
| cmd_clr_v | input | 1 | Clear the overflow flag |
| cmd_mask_set | input | 1 | Set low-byte bits selected by `cmd_mask` |
| cmd_mask_clr | input | 1 | Clear low-byte bits selected by `cmd_mask` |
| cmd_mask | input | 8 | Bit mask for the masked commands |
| pull_valid | input | 1 | Load the whole register from the stack |
| pull_data | input | 11 | Value popped from the stack |
| sr_out | output | 11 | Current register contents |

## Verification
A mode bit that is wrong shows up at the very next result: V and N are then drawn from the wrong lane. The 0x7FFF+1 and 0x007F+1 cases give opposite flags in the two modes, so they expose such an error within one clock. A lost priority or merge ordering, whether a set winning over a clear or a result winning over a command, is visible on `sr_out` in the cycle after the conflicting inputs. The priority field is watched across every cycle without a load, so a stray write to it is caught at once.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int SFR_MASK_W   = 8;
  localparam int SFR_PRIO_W   = 3;
  localparam int SFR_M_BIT    = 5;
  localparam int SFR_V_BIT    = 6;
  localparam int SFR_N_BIT    = 7;
  localparam int SFR_PRIO_LSB = SFR_MASK_W;
  localparam int SFR_W        = SFR_PRIO_LSB + SFR_PRIO_W;
  localparam int SFR_LANES    = 2;
  localparam int LANE_NARROW  = 0;
  localparam int LANE_WIDE    = 1;
endpackage

// File: rtl/sfr_rst_sync.sv
module sfr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sfr_flag_eval.sv
module sfr_flag_eval #(
  parameter int LANES = 2
) (
  input  logic             lane_narrow,
  input  logic [LANES-1:0] sign,
  input  logic [LANES-1:0] cin_msb,
  input  logic [LANES-1:0] cout_msb,
  output logic             neg,
  output logic             ovf
);
  localparam int L_NARROW = 0;
  localparam int L_WIDE   = LANES - 1;

  logic [LANES-1:0] lane_ovf;

  // signed overflow per lane: carry into the lane MSB differs from carry out
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_ovf[g] = cin_msb[g] ^ cout_msb[g];
    end
  endgenerate

  always_comb begin
    if (lane_narrow) begin
      neg = sign[L_NARROW];
      ovf = lane_ovf[L_NARROW];
    end else begin
      neg = sign[L_WIDE];
      ovf = lane_ovf[L_WIDE];
    end
  end
endmodule

// File: rtl/sfr_cmd_decode.sv
module sfr_cmd_decode #(
  parameter int MASK_W = 8,
  parameter int M_BIT  = 5,
  parameter int V_BIT  = 6
) (
  input  logic              set_m,
  input  logic              clr_m,
  input  logic              clr_v,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic [MASK_W-1:0] mask,
  output logic [MASK_W-1:0] set_vec,
  output logic [MASK_W-1:0] clr_vec
);
  genvar g;
  generate
    for (g = 0; g < MASK_W; g++) begin : g_bit
      if (g == M_BIT) begin : g_mode
        assign set_vec[g] = (mask_set & mask[g]) | set_m;
        assign clr_vec[g] = (mask_clr & mask[g]) | clr_m;
      end else if (g == V_BIT) begin : g_ovf
        assign set_vec[g] = mask_set & mask[g];
        assign clr_vec[g] = (mask_clr & mask[g]) | clr_v;
      end else begin : g_plain
        assign set_vec[g] = mask_set & mask[g];
        assign clr_vec[g] = mask_clr & mask[g];
      end
    end
  endgenerate
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sfr_pkg::*;
#(
  parameter int MASK_W = SFR_MASK_W,
  parameter int PRIO_W = SFR_PRIO_W,
  parameter int LANES  = SFR_LANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     res_valid,
  input  logic                     res_arith,
  input  logic                     dec_mode,
  input  logic [LANES-1:0]         res_sign,
  input  logic [LANES-1:0]         res_cin_msb,
  input  logic [LANES-1:0]         res_cout_msb,
  input  logic                     cmd_set_m,
  input  logic                     cmd_clr_m,
  input  logic                     cmd_clr_v,
  input  logic                     cmd_mask_set,
  input  logic                     cmd_mask_clr,
  input  logic [MASK_W-1:0]        cmd_mask,
  input  logic                     pull_valid,
  input  logic [MASK_W+PRIO_W-1:0] pull_data,
  output logic [MASK_W+PRIO_W-1:0] sr_out
);
  localparam int REG_W = MASK_W + PRIO_W;

  logic             rst_sync_n;
  logic [REG_W-1:0] sr_q, sr_d;
  logic             sr_en;
  logic             flag_neg, flag_ovf;
  logic [MASK_W-1:0] set_vec, clr_vec, low_mix;

  sfr_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_sync_n)
  );

  sfr_flag_eval #(.LANES(LANES)) u_eval (
    .lane_narrow(sr_q[SFR_M_BIT]),
    .sign       (res_sign),
    .cin_msb    (res_cin_msb),
    .cout_msb   (res_cout_msb),
    .neg        (flag_neg),
    .ovf        (flag_ovf)
  );

  sfr_cmd_decode #(
    .MASK_W(MASK_W),
    .M_BIT (SFR_M_BIT),
    .V_BIT (SFR_V_BIT)
  ) u_cmd (
    .set_m   (cmd_set_m),
    .clr_m   (cmd_clr_m),
    .clr_v   (cmd_clr_v),
    .mask_set(cmd_mask_set),
    .mask_clr(cmd_mask_clr),
    .mask    (cmd_mask),
    .set_vec (set_vec),
    .clr_vec (clr_vec)
  );

  // next state: result flags, then sets, then clears, then stack load on top
  always_comb begin
    low_mix = sr_q[MASK_W-1:0];
    if (res_valid && !dec_mode) begin
      low_mix[SFR_N_BIT] = flag_neg;
      if (res_arith) low_mix[SFR_V_BIT] = flag_ovf;
    end
    low_mix = (low_mix | set_vec) & ~clr_vec;
    sr_d = {sr_q[REG_W-1:MASK_W], low_mix};
    if (pull_valid) sr_d = pull_data;
  end

  assign sr_en = pull_valid | res_valid | (|set_vec) | (|clr_vec);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sr_q <= '0;
    else if (sr_en)   sr_q <= sr_d;
  end

  assign sr_out = sr_q;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int MASK_W = 8,
  parameter int PRIO_W = 3,
  parameter int LANES  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rst_sync_n,
  input logic                     res_valid,
  input logic                     dec_mode,
  input logic [LANES-1:0]         res_sign,
  input logic                     cmd_set_m,
  input logic                     cmd_clr_m,
  input logic                     cmd_clr_v,
  input logic                     cmd_mask_set,
  input logic                     cmd_mask_clr,
  input logic [MASK_W-1:0]        cmd_mask,
  input logic                     pull_valid,
  input logic [MASK_W+PRIO_W-1:0] pull_data,
  input logic [MASK_W+PRIO_W-1:0] sr_out
);
  localparam int REG_W = MASK_W + PRIO_W;

  logic any_cmd;
  assign any_cmd = cmd_set_m | cmd_clr_m | cmd_clr_v | cmd_mask_set | cmd_mask_clr;

  // R1: held clear while reset input is low
  always @(posedge clk) begin
    if (rst_n === 1'b0) assert_reset_clear_R1: assert (sr_out == '0);
  end

  assert_mode_clear_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_clr_m && !pull_valid) |=> !sr_out[5]);

  assert_narrow_neg_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && !dec_mode && !any_cmd && !pull_valid && sr_out[5])
      |=> sr_out[7] == $past(res_sign[0]));

  assert_dec_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && dec_mode && !any_cmd && !pull_valid) |=> $stable(sr_out[7:6]));

  assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_mask_clr && !pull_valid) |=> (sr_out[MASK_W-1:0] & $past(cmd_mask)) == '0);

  assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_clr_v && !pull_valid) |=> !sr_out[6]);

  assert_pull_load_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pull_valid |=> sr_out == $past(pull_data));

  assert_prio_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pull_valid |=> $stable(sr_out[REG_W-1:MASK_W]));
endmodule

bind status_flag_reg sfr_checker #(
  .MASK_W(MASK_W),
  .PRIO_W(PRIO_W),
  .LANES (LANES)
) u_sfr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .res_valid   (res_valid),
  .dec_mode    (dec_mode),
  .res_sign    (res_sign),
  .cmd_set_m   (cmd_set_m),
  .cmd_clr_m   (cmd_clr_m),
  .cmd_clr_v   (cmd_clr_v),
  .cmd_mask_set(cmd_mask_set),
  .cmd_mask_clr(cmd_mask_clr),
  .cmd_mask    (cmd_mask),
  .pull_valid  (pull_valid),
  .pull_data   (pull_data),
  .sr_out      (sr_out)
);

// File: tb/tb_status_flag_reg.sv
`timescale 1ns/1ps
module tb_status_flag_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid, res_arith, dec_mode;
  logic [1:0]  res_sign, res_cin_msb, res_cout_msb;
  logic        cmd_set_m, cmd_clr_m, cmd_clr_v, cmd_mask_set, cmd_mask_clr;
  logic [7:0]  cmd_mask;
  logic        pull_valid;
  logic [10:0] pull_data;
  logic [10:0] sr_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  status_flag_reg dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_arith(res_arith),
    .dec_mode(dec_mode), .res_sign(res_sign), .res_cin_msb(res_cin_msb),
    .res_cout_msb(res_cout_msb), .cmd_set_m(cmd_set_m), .cmd_clr_m(cmd_clr_m),
    .cmd_clr_v(cmd_clr_v), .cmd_mask_set(cmd_mask_set), .cmd_mask_clr(cmd_mask_clr),
    .cmd_mask(cmd_mask), .pull_valid(pull_valid), .pull_data(pull_data),
    .sr_out(sr_out)
  );

  task automatic idle_inputs();
    res_valid = 0; res_arith = 0; dec_mode = 0;
    res_sign = '0; res_cin_msb = '0; res_cout_msb = '0;
    cmd_set_m = 0; cmd_clr_m = 0; cmd_clr_v = 0;
    cmd_mask_set = 0; cmd_mask_clr = 0; cmd_mask = '0;
    pull_valid = 0; pull_data = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic check(input string req, input logic [10:0] exp);
    n_checks++;
    if (sr_out !== exp) begin
      n_fails++;
      $display("FAIL %s: sr_out=%03h expected=%03h", req, sr_out, exp);
    end
  endtask

  // ripple-carry model of an adder: drives sign bits and lane carries
  task automatic present_add(input logic [15:0] a, input logic [15:0] b,
                             input logic arith, input logic dec);
    logic [16:0] c;
    logic [15:0] s;
    c[0] = 1'b0;
    for (int i = 0; i < 16; i++) begin
      s[i]   = a[i] ^ b[i] ^ c[i];
      c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end
    res_valid    = 1'b1;
    res_arith    = arith;
    dec_mode     = dec;
    res_sign     = {s[15], s[7]};
    res_cin_msb  = {c[15], c[7]};
    res_cout_msb = {c[16], c[8]};
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    #1;
    check("R1 reset asserted", 11'h000);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release", 11'h000);
  endtask

  task automatic t_wide_flags();
    present_add(16'h7FFF, 16'h0001, 1, 0); step();
    check("R3 R5 wide overflow and sign", 11'h0C0);
    present_add(16'h0001, 16'h0001, 1, 0); step();
    check("R3 R5 wide in range", 11'h000);
  endtask

  task automatic t_narrow_flags();
    cmd_set_m = 1; step();
    check("R2 set mode", 11'h020);
    present_add(16'h007F, 16'h0001, 1, 0); step();
    check("R4 R5 narrow overflow and sign", 11'h0E0);
    present_add(16'h7FFF, 16'h0001, 1, 0); step();
    check("R4 narrow ignores 16-bit carry", 11'h020);
  endtask

  task automatic t_transfer_dec();
    cmd_mask_set = 1; cmd_mask = 8'h40; step();
    check("R8 mask set V", 11'h060);
    present_add(16'h0080, 16'h0000, 0, 0); step();
    check("R6 transfer keeps V sets N", 11'h0E0);
    present_add(16'h0001, 16'h0001, 1, 1); step();
    check("R7 decimal holds V N", 11'h0E0);
  endtask

  task automatic t_commands();
    cmd_clr_v = 1; step();
    check("R9 clear V", 11'h0A0);
    cmd_mask_clr = 1; cmd_mask = 8'h00; step();
    check("R8 zero mask no change", 11'h0A0);
    cmd_mask_clr = 1; cmd_mask = 8'hFF; step();
    check("R8 mask clear all", 11'h000);
    cmd_mask_set = 1; cmd_mask = 8'h1F; step();
    check("R8 mask set low flags", 11'h01F);
    cmd_set_m = 1; cmd_clr_m = 1; step();
    check("R2 R9 clear wins over set", 11'h01F);
    present_add(16'h4000, 16'h4000, 1, 0);
    cmd_mask_clr = 1; cmd_mask = 8'h80; step();
    check("R9 command overrides result N", 11'h05F);
  endtask

  task automatic t_old_mode();
    present_add(16'h0080, 16'h0000, 1, 0);
    cmd_set_m = 1; step();
    check("R11 result uses prior mode", 11'h03F);
  endtask

  task automatic t_pull();
    pull_valid = 1; pull_data = 11'h7A5; step();
    check("R10 pull load", 11'h7A5);
    pull_valid = 1; pull_data = 11'h300;
    cmd_set_m = 1; cmd_mask_set = 1; cmd_mask = 8'hFF;
    present_add(16'h7FFF, 16'h0001, 1, 0); step();
    check("R10 pull overrides all", 11'h300);
    cmd_mask_set = 1; cmd_mask = 8'hFF; step();
    check("R10 mask set keeps priority", 11'h3FF);
    cmd_mask_clr = 1; cmd_mask = 8'hFF; step();
    check("R10 mask clear keeps priority", 11'h300);
  endtask

  task automatic t_reset_midrun();
    #1 rst_n = 1'b0;
    #1;
    check("R1 reset mid-run", 11'h000);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after second release", 11'h000);
  endtask

  initial begin
    t_reset();
    t_wide_flags();
    t_narrow_flags();
    t_transfer_dec();
    t_commands();
    t_old_mode();
    t_pull();
    t_reset_midrun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule